// File: doc/BRIEF.md
# Reset Source Capture Controller

This block merges four reset request sources into one stretched system reset and remembers which source caused the latest reset. The sources are a guard on the CPU address bus that flags accesses landing in two fixed unmapped gaps, a clock-generator fault line, a low-voltage line, and a force-reset write that only a debug host can make. The low-voltage source is gated by two enable bits. It is also gated by the stop-mode flag, and a third enable bit lets it stay active in stop mode.

A cause register records one bit per hardware source. The reset it helps to produce does not clear it, so firmware can read it once the reset has ended. Only power-on clears it, and power-on leaves the low-voltage bit set. The force-reset location is write-only and always reads as zero. A write to it takes effect only when the debug-access qualifier comes with the write.

Top module: `rst_cause_ctrl`

## Requirements
- R1: A valid bus access (read or write) whose address is in 0x0880–0x17FF or 0x182C–0xBFFF requests a reset, and the cause register becomes 0x08 (bit 3).
- R2: A bus access outside both gaps does not request a reset. This covers 0x087F, 0x1800–0x182B and 0xC000 upward.
- R3: The cause register reads at address 0x1800. Bit 2 records a clock fault and bit 1 records a low-voltage reset. After a sourced reset exactly one of bits 3..1 is set, and bits 7..4 and bit 0 read as 0.
- R4: A low-voltage reset happens only when the low-voltage input, the detect enable and the reset enable are all 1.
- R5: While the stop-mode flag is 1, the low-voltage input causes no reset unless the stop enable is also 1.
- R6: Power-on reset sets the cause register to 0x02 and holds the reset output high for 8 cycles after power-on is released.
- R7: The force-reset location at 0x1801 always reads 0x00.
- R8: A write to 0x1801 with data bit 0 set and the debug qualifier high forces a reset and leaves bits 3..1 at 0. The same write without the qualifier, or with bit 0 clear, has no effect.
- R9: When several sources request in the same cycle, priority runs illegal address, then clock fault, then low voltage, then debug force. Only the highest one is recorded.
- R10: The reset output rises the cycle after a request and stays high for exactly 8 cycles. Requests made while it is high are ignored and leave the cause register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| bus_valid | input | 1 | Address strobe for a CPU or debug access |
| bus_addr | input | 16 | Access address |
| bus_write | input | 1 | 1 for a write, 0 for a read |
| bus_dbg | input | 1 | Access comes from the debug host |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational |
| clk_fault | input | 1 | Clock generator fault request |
| lv_detect | input | 1 | Supply below the trip level |
| lv_det_en | input | 1 | Low-voltage detect enable |
| lv_rst_en | input | 1 | Low-voltage reset enable |
| stop_mode | input | 1 | Device is in stop mode |
| lv_stop_en | input | 1 | Keep low-voltage detection active in stop |
| sys_rst | output | 1 | Stretched system reset, active high |

## Verification
On every cycle the assertions check the following: the stretch length, that the cause register stays stable while the reset is high, that the cause bits are one-hot, that the force location reads zero, that a gap access starts a reset, that a non-debug force write is ignored, and that low-voltage gating works. Only the bench scenarios can show the rest. That covers the exact gap edges, the priority order under simultaneous requests, the stop-mode override, the power-on value, and that the cause survives the reset it caused. The bench checks each of these against a model of the cause register, using a mix of directed cases and seeded random cases.

// File: rtl/rcc_pkg.sv
package rcc_pkg;
    localparam int CAUSE_W   = 8;
    localparam int BIT_ILL   = 3;
    localparam int BIT_CLK   = 2;
    localparam int BIT_LV    = 1;

    typedef struct packed {
        logic ill;
        logic clk;
        logic lv;
        logic dbg;
    } rcc_req_t;

    localparam logic [CAUSE_W-1:0] CAUSE_POR = CAUSE_W'(1) << BIT_LV;
endpackage

// File: rtl/rcc_addr_guard.sv
module rcc_addr_guard #(
    parameter int AW       = 16,
    parameter int NUM_GAPS = 2,
    parameter logic [NUM_GAPS-1:0][AW-1:0] GAP_LO = {16'h182C, 16'h0880},
    parameter logic [NUM_GAPS-1:0][AW-1:0] GAP_HI = {16'hBFFF, 16'h17FF}
) (
    input  logic          valid,
    input  logic [AW-1:0] addr,
    output logic          illegal
);
    logic [NUM_GAPS-1:0] hit;

    for (genvar g = 0; g < NUM_GAPS; g++) begin : g_gap
        assign hit[g] = (addr >= GAP_LO[g]) && (addr <= GAP_HI[g]);
    end

    assign illegal = valid && (|hit);
endmodule

// File: rtl/rcc_lv_gate.sv
module rcc_lv_gate (
    input  logic lv_detect,
    input  logic det_en,
    input  logic rst_en,
    input  logic stop_mode,
    input  logic stop_en,
    output logic lv_req
);
    logic armed;
    assign armed  = det_en && rst_en && (!stop_mode || stop_en);
    assign lv_req = armed && lv_detect;
endmodule

// File: rtl/rcc_cause_pick.sv
module rcc_cause_pick
    import rcc_pkg::*;
(
    input  rcc_req_t             req,
    output logic                 any,
    output logic [CAUSE_W-1:0]   cause
);
    always_comb begin
        cause = '0;
        if (req.ill)      cause[BIT_ILL] = 1'b1;
        else if (req.clk) cause[BIT_CLK] = 1'b1;
        else if (req.lv)  cause[BIT_LV]  = 1'b1;
        // a debug force leaves every cause bit clear
    end
    assign any = req.ill || req.clk || req.lv || req.dbg;
endmodule

// File: rtl/rst_cause_ctrl.sv
module rst_cause_ctrl
    import rcc_pkg::*;
#(
    parameter int AW         = 16,
    parameter int DW         = 8,
    parameter int STRETCH    = 8,
    parameter logic [AW-1:0] STAT_ADDR  = 16'h1800,
    parameter logic [AW-1:0] FORCE_ADDR = 16'h1801,
    parameter int NUM_GAPS   = 2,
    parameter logic [NUM_GAPS-1:0][AW-1:0] GAP_LO = {16'h182C, 16'h0880},
    parameter logic [NUM_GAPS-1:0][AW-1:0] GAP_HI = {16'hBFFF, 16'h17FF}
) (
    input  logic          clk,
    input  logic          por_n,
    input  logic          bus_valid,
    input  logic [AW-1:0] bus_addr,
    input  logic          bus_write,
    input  logic          bus_dbg,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    input  logic          clk_fault,
    input  logic          lv_detect,
    input  logic          lv_det_en,
    input  logic          lv_rst_en,
    input  logic          stop_mode,
    input  logic          lv_stop_en,
    output logic          sys_rst
);
    localparam int CW = $clog2(STRETCH + 1);

    typedef struct packed {
        logic [CW-1:0]      cnt;
        logic [CAUSE_W-1:0] cause;
    } state_t;

    state_t st_d, st_q;
    rcc_req_t req;
    logic req_any;
    logic [CAUSE_W-1:0] pick;
    logic [CAUSE_W-1:0] cause_q;
    logic unused_wdata_hi;

    rcc_addr_guard #(
        .AW(AW), .NUM_GAPS(NUM_GAPS), .GAP_LO(GAP_LO), .GAP_HI(GAP_HI)
    ) guard_i (
        .valid(bus_valid), .addr(bus_addr), .illegal(req.ill)
    );

    rcc_lv_gate lv_i (
        .lv_detect(lv_detect), .det_en(lv_det_en), .rst_en(lv_rst_en),
        .stop_mode(stop_mode), .stop_en(lv_stop_en), .lv_req(req.lv)
    );

    assign req.clk = clk_fault;
    assign req.dbg = bus_valid && bus_write && bus_dbg
                     && (bus_addr == FORCE_ADDR) && bus_wdata[0];
    assign unused_wdata_hi = ^bus_wdata[DW-1:1];

    rcc_cause_pick pick_i (.req(req), .any(req_any), .cause(pick));

    always_comb begin
        st_d = st_q;
        if (st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - 1'b1;
        end else if (req_any) begin
            st_d.cnt   = CW'(STRETCH);
            st_d.cause = pick;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            st_q.cnt   <= CW'(STRETCH);
            st_q.cause <= CAUSE_POR;
        end else begin
            st_q <= st_d;
        end
    end

    assign cause_q = st_q.cause;
    assign sys_rst = (st_q.cnt != '0);

    always_comb begin
        bus_rdata = '0;
        if (bus_valid && !bus_write && (bus_addr == STAT_ADDR))
            bus_rdata = DW'(cause_q);
    end
endmodule

// File: rtl/rcc_checker.sv
module rcc_checker #(
    parameter int AW      = 16,
    parameter int STRETCH = 8,
    parameter logic [AW-1:0] FORCE_ADDR = 16'h1801
) (
    input logic          clk,
    input logic          por_n,
    input logic          bus_valid,
    input logic [AW-1:0] bus_addr,
    input logic          bus_write,
    input logic          bus_dbg,
    input logic [7:0]    bus_rdata,
    input logic          clk_fault,
    input logic          lv_detect,
    input logic          lv_det_en,
    input logic          lv_rst_en,
    input logic          sys_rst,
    input logic [7:0]    cause
);
    logic [31:0] hi_cnt_q;
    logic        in_gap;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) hi_cnt_q <= '0;
        else        hi_cnt_q <= sys_rst ? hi_cnt_q + 1 : '0;
    end

    assign in_gap = ((bus_addr >= 16'h0880) && (bus_addr <= 16'h17FF))
                 || ((bus_addr >= 16'h182C) && (bus_addr <= 16'hBFFF));

    a_r10_stretch_len: assert property (@(posedge clk) disable iff (!por_n)
        $fell(sys_rst) |-> hi_cnt_q == STRETCH);

    a_r10_hold_cause: assert property (@(posedge clk) disable iff (!por_n)
        sys_rst |=> $stable(cause));

    a_r3_onehot_cause: assert property (@(posedge clk) disable iff (!por_n)
        $onehot0(cause[3:1]) && cause[7:4] == 4'h0 && !cause[0]);

    a_r7_force_reads_zero: assert property (@(posedge clk) disable iff (!por_n)
        (bus_valid && !bus_write && bus_addr == FORCE_ADDR) |-> bus_rdata == 8'h00);

    a_r1_gap_resets: assert property (@(posedge clk) disable iff (!por_n)
        (!sys_rst && bus_valid && in_gap) |=> (sys_rst && cause == 8'h08));

    a_r8_user_write_ignored: assert property (@(posedge clk) disable iff (!por_n)
        (!sys_rst && bus_valid && bus_write && !bus_dbg && bus_addr == FORCE_ADDR
         && !clk_fault && !lv_detect) |=> !sys_rst);

    a_r4_lv_needs_enables: assert property (@(posedge clk) disable iff (!por_n)
        (!sys_rst && !bus_valid && !clk_fault && !(lv_det_en && lv_rst_en)) |=> !sys_rst);
endmodule

bind rst_cause_ctrl rcc_checker #(
    .AW(AW), .STRETCH(STRETCH), .FORCE_ADDR(FORCE_ADDR)
) chk_i (
    .clk(clk), .por_n(por_n), .bus_valid(bus_valid), .bus_addr(bus_addr),
    .bus_write(bus_write), .bus_dbg(bus_dbg), .bus_rdata(bus_rdata),
    .clk_fault(clk_fault), .lv_detect(lv_detect), .lv_det_en(lv_det_en),
    .lv_rst_en(lv_rst_en), .sys_rst(sys_rst), .cause(cause_q)
);

// File: tb/rst_cause_ctrl_tb_top.sv
module rst_cause_ctrl_tb_top;
    localparam int STRETCH = 8;
    localparam logic [15:0] STAT  = 16'h1800;
    localparam logic [15:0] FORCE = 16'h1801;

    logic clk = 1'b0;
    logic por_n = 1'b0;
    logic bus_valid = 0, bus_write = 0, bus_dbg = 0;
    logic [15:0] bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic clk_fault = 0, lv_detect = 0, lv_det_en = 0, lv_rst_en = 0;
    logic stop_mode = 0, lv_stop_en = 0;
    logic sys_rst;

    int checks = 0, errors = 0;
    logic [7:0] model_cause;
    bit done = 0;

    always #2.5 clk = ~clk;

    rst_cause_ctrl dut_i (
        .clk(clk), .por_n(por_n), .bus_valid(bus_valid), .bus_addr(bus_addr),
        .bus_write(bus_write), .bus_dbg(bus_dbg), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .clk_fault(clk_fault), .lv_detect(lv_detect),
        .lv_det_en(lv_det_en), .lv_rst_en(lv_rst_en), .stop_mode(stop_mode),
        .lv_stop_en(lv_stop_en), .sys_rst(sys_rst)
    );

    function automatic bit in_gap(input logic [15:0] a);
        return (a >= 16'h0880 && a <= 16'h17FF) || (a >= 16'h182C && a <= 16'hBFFF);
    endfunction

    function automatic logic [7:0] exp_cause(input bit ill, input bit cf, input bit lv);
        if (ill) return 8'h08;
        if (cf)  return 8'h04;
        if (lv)  return 8'h02;
        return 8'h00;
    endfunction

    function automatic bit lv_fires(input bit d, input bit de, input bit re,
                                    input bit sm, input bit se);
        return d && de && re && (!sm || se);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic clear_stim();
        bus_valid = 0; bus_write = 0; bus_dbg = 0; bus_addr = '0; bus_wdata = '0;
        clk_fault = 0; lv_detect = 0;
    endtask

    task automatic read_cause(input string req);
        bus_valid = 1; bus_write = 0; bus_addr = STAT;
        #1;
        chk(bus_rdata == model_cause, req, bus_rdata, model_cause);
        bus_valid = 0; bus_addr = '0;
    endtask

    // inputs already driven at a negedge; capture at posedge and check
    task automatic step(input bit exp_rst, input logic [7:0] cause_if_rst, input string req);
        int n;
        @(posedge clk);
        @(negedge clk);
        clear_stim();
        chk(sys_rst == exp_rst, req, sys_rst, exp_rst);
        if (exp_rst) begin
            model_cause = cause_if_rst;
            n = 0;
            while (sys_rst && n < 100) begin n++; @(negedge clk); end
            chk(n == STRETCH, "R10", n, STRETCH);
        end
        read_cause(req);
    endtask

    task automatic access(input logic [15:0] a, input bit w, input bit d, input logic [7:0] wd);
        bus_valid = 1; bus_addr = a; bus_write = w; bus_dbg = d; bus_wdata = wd;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int n;
        bit ill, lvf, dbgw, any;
        logic [15:0] a;
        void'($urandom(32'd1234));
        model_cause = 8'h02;

        // R6: power-on
        repeat (3) @(negedge clk);
        chk(sys_rst == 1'b1, "R6", sys_rst, 1);
        por_n = 1'b1;
        n = 0;
        while (sys_rst && n < 100) begin n++; @(negedge clk); end
        chk(n == STRETCH, "R6", n, STRETCH);
        read_cause("R6");

        // R7: force location reads zero
        access(FORCE, 0, 0, 8'h00); #1;
        chk(bus_rdata == 8'h00, "R7", bus_rdata, 0);
        access(FORCE, 0, 1, 8'h00); #1;
        chk(bus_rdata == 8'h00, "R7", bus_rdata, 0);
        clear_stim();

        // R1 / R2 gap boundaries
        begin
            logic [15:0] edges [9] = '{16'h087F, 16'h0880, 16'h17FF, 16'h1800,
                                       16'h182B, 16'h182C, 16'hBFFF, 16'hC000, 16'h0000};
            foreach (edges[i]) begin
                @(negedge clk);
                access(edges[i], 0, 0, 8'h00);
                step(in_gap(edges[i]), 8'h08, in_gap(edges[i]) ? "R1" : "R2");
            end
        end
        // R1: write into gap
        @(negedge clk); access(16'h4000, 1, 0, 8'hFF); step(1, 8'h08, "R1");

        // R3: clock fault alone
        @(negedge clk); clk_fault = 1; step(1, 8'h04, "R3");

        // R4: lv gating by enables
        lv_det_en = 1; lv_rst_en = 0;
        @(negedge clk); lv_detect = 1; step(0, 8'h00, "R4");
        lv_det_en = 0; lv_rst_en = 1;
        @(negedge clk); lv_detect = 1; step(0, 8'h00, "R4");
        lv_det_en = 1; lv_rst_en = 1;
        @(negedge clk); lv_detect = 1; step(1, 8'h02, "R4");

        // R5: stop-mode gating
        @(negedge clk); clk_fault = 1; step(1, 8'h04, "R5");
        stop_mode = 1; lv_stop_en = 0;
        @(negedge clk); lv_detect = 1; step(0, 8'h00, "R5");
        lv_stop_en = 1;
        @(negedge clk); lv_detect = 1; step(1, 8'h02, "R5");
        stop_mode = 0; lv_stop_en = 0;

        // R8: debug force
        @(negedge clk); clk_fault = 1; step(1, 8'h04, "R8");
        @(negedge clk); access(FORCE, 1, 0, 8'h01); step(0, 8'h00, "R8");
        @(negedge clk); access(FORCE, 1, 1, 8'hFE); step(0, 8'h00, "R8");
        @(negedge clk); access(FORCE, 1, 1, 8'h01); step(1, 8'h00, "R8");

        // R9: priority
        @(negedge clk); access(16'h1000, 0, 0, 8'h00); clk_fault = 1; lv_detect = 1;
        step(1, 8'h08, "R9");
        @(negedge clk); clk_fault = 1; lv_detect = 1; step(1, 8'h04, "R9");
        @(negedge clk); access(FORCE, 1, 1, 8'h01); lv_detect = 1; step(1, 8'h02, "R9");

        // R10: requests during stretch ignored
        @(negedge clk); access(16'h2000, 0, 0, 8'h00);
        @(posedge clk); @(negedge clk); clear_stim();
        model_cause = 8'h08;
        n = 0;
        while (sys_rst && n < 100) begin
            n++;
            clk_fault = (n == 2 || n == 8);
            @(negedge clk);
        end
        clk_fault = 0;
        chk(n == STRETCH, "R10", n, STRETCH);
        @(negedge clk);
        chk(sys_rst == 1'b0, "R10", sys_rst, 0);
        read_cause("R10");

        // random mix
        for (int it = 0; it < 300; it++) begin
            @(negedge clk);
            case ($urandom % 4)
                0: a = 16'h0880 + 16'($urandom % 16'h0F80);
                1: a = FORCE;
                2: a = 16'h1800 + 16'($urandom % 16'h002C);
                default: a = 16'($urandom);
            endcase
            access(a, 1'($urandom), 1'($urandom), 8'($urandom));
            bus_valid = ($urandom % 4) != 0;
            clk_fault = ($urandom % 8) == 0;
            lv_detect = ($urandom % 3) == 0;
            lv_det_en = 1'($urandom); lv_rst_en = 1'($urandom);
            stop_mode = 1'($urandom); lv_stop_en = 1'($urandom);
            ill  = bus_valid && in_gap(a);
            lvf  = lv_fires(lv_detect, lv_det_en, lv_rst_en, stop_mode, lv_stop_en);
            dbgw = bus_valid && bus_write && bus_dbg && a == FORCE && bus_wdata[0];
            any  = ill || clk_fault || lvf || dbgw;
            step(any, exp_cause(ill, clk_fault, lvf), "R9");
        end

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule